// File: doc/BRIEF.md
# Parallel Display Bus Master (8-bit, 8080 style)

This block lets a host move 16-bit words to and from a display controller across an 8-bit parallel bus with separate read and write strobes. The host raises `req_valid` for one cycle with a request kind and a word. The block then runs one bus transaction and answers with a one-cycle `done`. A word is carried as consecutive byte cycles, most significant byte first. The block drives the data pins only while it writes, and it assembles read bytes back into a word.

All strobe timing comes from nanosecond parameters and the clock period. Each count is rounded up to whole cycles. The write set-up time, write-low width, write hold/idle time, read-low width, read sample point and the gap between read bytes are each set on their own. A fourth request kind produces a reset pulse on the display's reset line, with a length counted in cycles.

The controller has nine states. `ST_IDLE` accepts a request: a pulse request goes to `ST_RST_PULSE`, a read goes to `ST_RD_TURN`, and any write goes to `ST_WR_SETUP`. The write path is `ST_WR_SETUP` → `ST_WR_LOW` → `ST_WR_HOLD`. From `ST_WR_HOLD` it returns to `ST_WR_SETUP` for the next byte, or moves to `ST_FINISH` after the last byte. The read path is `ST_RD_TURN` → `ST_RD_LOW` → `ST_RD_GAP`. From `ST_RD_GAP` it returns to `ST_RD_LOW` for the next byte, or moves to `ST_FINISH` after the last byte. `ST_RST_PULSE` → `ST_FINISH` when its count expires, and `ST_FINISH` → `ST_IDLE` always.

Top module: `lcd_pbus_master`

## Requirements
- R1: Out of reset and whenever `busy` is low, `bus_cs_n`, `bus_wr_n`, `bus_rd_n` and `bus_res_n` are high, `bus_dc` is high, the data pins are released, and `done` is low.
- R2: A write request (kind 2'b00 command, 2'b01 data) produces exactly two write strobes. The first carries `req_word[15:8]` and the second carries `req_word[7:0]`. Each byte is valid when `bus_wr_n` rises.
- R3: `bus_dc` is low for both bytes of a command write. It is high for data writes, for reads and whenever no command is in progress, so it is back high by the time `done` is raised.
- R4: Each `bus_wr_n` low period lasts exactly ceil(WR_LOW_NS/CLK_NS) cycles (3 at defaults). The byte is already driven in the cycle before `bus_wr_n` falls and stays unchanged through the low period.
- R5: Each `bus_rd_n` low period lasts exactly the larger of ceil(RD_SAMPLE_NS/CLK_NS) and ceil(RD_LOW_NS/CLK_NS) cycles (13 at defaults). The byte is sampled at the clock edge that ends the last low cycle.
- R6: A read request (kind 2'b10) returns `rd_word` = first byte << 8 | second byte, valid while `done` is high.
- R7: The block never drives the data pins while `bus_rd_n` is low, and it has already released them in the cycle before any `bus_rd_n` fall.
- R8: Between the two byte reads of one word, `bus_rd_n` stays high for exactly ceil(RD_GAP_NS/CLK_NS) cycles (3 at defaults).
- R9: `bus_cs_n` falls once per word transfer and stays low across both byte cycles. Strobes are active only while it is low.
- R10: A pulse request (kind 2'b11) holds `bus_res_n` low for exactly RST_CYC cycles (10 at defaults). During the pulse `busy` is high, `bus_cs_n` is high and no write strobe occurs.
- R11: `busy` is high from the cycle after a request is accepted until `ST_FINISH`. `done` is high for exactly one cycle. Requests that arrive while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_kind | input | 2 | 00 command write, 01 data write, 10 data read, 11 reset pulse |
| req_word | input | 16 | Word to write |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_word | output | 16 | Assembled read word |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_dc | output | 1 | Low = command, high = data |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_res_n | output | 1 | Display reset, active low |
| bus_d | inout | 8 | Bidirectional data byte |

## Verification
Two events can fall in the same cycle: a new host request, and the internal advance from one byte cycle to the next (or to `ST_FINISH`). The bench provokes this by raising a second request, with a different kind and word, in the middle of a data write. It then judges the result at the pins: only the two original bytes must appear, both with `bus_dc` high, and `busy` must fall and stay low with no extra transaction. A panel model drives a wrong byte on the data pins until the final read-low cycle. A sample taken one cycle early therefore shows up as a wrong `rd_word`.

// File: rtl/lcd_pbus_pkg.sv
`timescale 1ns/1ps
package lcd_pbus_pkg;

    typedef enum logic [1:0] {
        REQ_CMD   = 2'b00,
        REQ_WDATA = 2'b01,
        REQ_RDATA = 2'b10,
        REQ_PULSE = 2'b11
    } req_kind_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RST_PULSE,
        ST_WR_SETUP,
        ST_WR_LOW,
        ST_WR_HOLD,
        ST_RD_TURN,
        ST_RD_LOW,
        ST_RD_GAP,
        ST_FINISH
    } bus_state_e;

    // Nanoseconds to whole clock cycles, rounded up, never below one.
    function automatic int unsigned ns_to_cycles(int unsigned ns, int unsigned period);
        int unsigned c;
        c = (ns + period - 1) / period;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/lcd_pbus_timer.sv
`timescale 1ns/1ps
// Down counter that measures the time spent in one controller state.
module lcd_pbus_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/lcd_pbus_packer.sv
`timescale 1ns/1ps
// Splits the outgoing word into bytes (most significant first) and
// shifts incoming bytes into a word.
module lcd_pbus_packer #(
    parameter int BYTE_W = 8,
    parameter int NBYTES = 2,
    localparam int WORD_W = BYTE_W * NBYTES,
    localparam int IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] word_in,
    input  logic              advance,
    input  logic              capture,
    input  logic [BYTE_W-1:0] cap_byte,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              is_last,
    output logic [WORD_W-1:0] rx_word
);

    logic [WORD_W-1:0] tx_word;
    logic [IDX_W-1:0]  idx;
    logic [WORD_W-1:0] rx_shift;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_word <= '0;
            idx     <= '0;
        end else if (start) begin
            tx_word <= word_in;
            idx     <= '0;
        end else if (advance) begin
            idx     <= idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_shift <= '0;
        end else if (start) begin
            rx_shift <= '0;
        end else if (capture) begin
            rx_shift <= {rx_shift[WORD_W-BYTE_W-1:0], cap_byte};
        end
    end

    // Byte 0 on the bus is the most significant slice of the word.
    always_comb begin
        tx_byte = '0;
        for (int b = 0; b < NBYTES; b++) begin
            if (idx == IDX_W'(NBYTES - 1 - b)) begin
                tx_byte = tx_word[b*BYTE_W +: BYTE_W];
            end
        end
    end

    assign is_last = (idx == IDX_W'(NBYTES - 1));
    assign rx_word = rx_shift;

endmodule

// File: rtl/lcd_pbus_master.sv
`timescale 1ns/1ps
module lcd_pbus_master
    import lcd_pbus_pkg::*;
#(
    parameter int unsigned CLK_NS       = 20,
    parameter int unsigned WR_SETUP_NS  = 20,
    parameter int unsigned WR_LOW_NS    = 50,
    parameter int unsigned WR_IDLE_NS   = 20,
    parameter int unsigned RD_LOW_NS    = 150,
    parameter int unsigned RD_SAMPLE_NS = 250,
    parameter int unsigned RD_GAP_NS    = 60,
    parameter int unsigned RST_CYC      = 10,
    parameter int          BYTE_W       = 8,
    parameter int          NBYTES       = 2,
    localparam int         WORD_W       = BYTE_W * NBYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [WORD_W-1:0] req_word,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] rd_word,
    output logic              bus_cs_n,
    output logic              bus_dc,
    output logic              bus_wr_n,
    output logic              bus_rd_n,
    output logic              bus_res_n,
    inout  wire  [BYTE_W-1:0] bus_d
);

    localparam int unsigned SETUP_CYC = ns_to_cycles(WR_SETUP_NS, CLK_NS);
    localparam int unsigned WR_CYC    = ns_to_cycles(WR_LOW_NS, CLK_NS);
    localparam int unsigned IDLE_CYC  = ns_to_cycles(WR_IDLE_NS, CLK_NS);
    localparam int unsigned RD_CYC    = max2(ns_to_cycles(RD_SAMPLE_NS, CLK_NS),
                                             ns_to_cycles(RD_LOW_NS, CLK_NS));
    localparam int unsigned GAP_CYC   = ns_to_cycles(RD_GAP_NS, CLK_NS);
    localparam int unsigned PULSE_CYC = (RST_CYC < 1) ? 1 : RST_CYC;
    localparam int unsigned MAX_CYC   = max2(max2(max2(SETUP_CYC, WR_CYC), max2(IDLE_CYC, RD_CYC)),
                                             max2(GAP_CYC, PULSE_CYC));
    localparam int          CNT_W     = $clog2(MAX_CYC + 1);

    bus_state_e        state, state_nx;
    req_kind_e         kind_q;
    logic              accept;
    logic              tmr_load, tmr_exp;
    logic [CNT_W-1:0]  tmr_val;
    logic              advance, capture, is_last;
    logic [BYTE_W-1:0] tx_byte;
    logic              drive_en;

    assign accept = (state == ST_IDLE) && req_valid;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= REQ_WDATA;
        end else if (accept) begin
            kind_q <= req_kind_e'(req_kind);
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    unique case (req_kind_e'(req_kind))
                        REQ_PULSE: state_nx = ST_RST_PULSE;
                        REQ_RDATA: state_nx = ST_RD_TURN;
                        default:   state_nx = ST_WR_SETUP;
                    endcase
                end
            end
            ST_RST_PULSE: if (tmr_exp) state_nx = ST_FINISH;
            ST_WR_SETUP:  if (tmr_exp) state_nx = ST_WR_LOW;
            ST_WR_LOW:    if (tmr_exp) state_nx = ST_WR_HOLD;
            ST_WR_HOLD:   if (tmr_exp) state_nx = is_last ? ST_FINISH : ST_WR_SETUP;
            ST_RD_TURN:   if (tmr_exp) state_nx = ST_RD_LOW;
            ST_RD_LOW:    if (tmr_exp) state_nx = ST_RD_GAP;
            ST_RD_GAP:    if (tmr_exp) state_nx = is_last ? ST_FINISH : ST_RD_LOW;
            ST_FINISH:    state_nx = ST_IDLE;
            default:      state_nx = ST_IDLE;
        endcase
    end

    // Duration of the state about to be entered
    always_comb begin
        unique case (state_nx)
            ST_RST_PULSE: tmr_val = CNT_W'(PULSE_CYC - 1);
            ST_WR_SETUP:  tmr_val = CNT_W'(SETUP_CYC - 1);
            ST_WR_LOW:    tmr_val = CNT_W'(WR_CYC - 1);
            ST_WR_HOLD:   tmr_val = CNT_W'(IDLE_CYC - 1);
            ST_RD_LOW:    tmr_val = CNT_W'(RD_CYC - 1);
            ST_RD_GAP:    tmr_val = CNT_W'(GAP_CYC - 1);
            default:      tmr_val = '0;
        endcase
    end

    assign tmr_load = (state_nx != state);
    assign advance  = tmr_exp && !is_last &&
                      ((state == ST_WR_HOLD) || (state == ST_RD_GAP));
    assign capture  = tmr_exp && (state == ST_RD_LOW);

    lcd_pbus_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    lcd_pbus_packer #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_packer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept),
        .word_in  (req_word),
        .advance  (advance),
        .capture  (capture),
        .cap_byte (bus_d),
        .tx_byte  (tx_byte),
        .is_last  (is_last),
        .rx_word  (rd_word)
    );

    // Output decode
    always_comb begin
        bus_cs_n  = 1'b1;
        bus_dc    = 1'b1;
        bus_wr_n  = 1'b1;
        bus_rd_n  = 1'b1;
        bus_res_n = 1'b1;
        drive_en  = 1'b0;
        busy      = 1'b1;
        done      = 1'b0;
        unique case (state)
            ST_IDLE:      busy = 1'b0;
            ST_RST_PULSE: bus_res_n = 1'b0;
            ST_WR_SETUP, ST_WR_HOLD: begin
                bus_cs_n = 1'b0;
                bus_dc   = (kind_q != REQ_CMD);
                drive_en = 1'b1;
            end
            ST_WR_LOW: begin
                bus_cs_n = 1'b0;
                bus_dc   = (kind_q != REQ_CMD);
                drive_en = 1'b1;
                bus_wr_n = 1'b0;
            end
            ST_RD_TURN, ST_RD_GAP: bus_cs_n = 1'b0;
            ST_RD_LOW: begin
                bus_cs_n = 1'b0;
                bus_rd_n = 1'b0;
            end
            ST_FINISH:    done = 1'b1;
            default:      busy = 1'b0;
        endcase
    end

    assign bus_d = drive_en ? tx_byte : {BYTE_W{1'bz}};

endmodule

// File: rtl/lcd_pbus_checker.sv
`timescale 1ns/1ps
module lcd_pbus_checker #(
    parameter int unsigned WR_CYC = 1,
    parameter int unsigned RD_CYC = 1
) (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic drive_en,
    input logic bus_cs_n,
    input logic bus_dc,
    input logic bus_wr_n,
    input logic bus_rd_n,
    input logic bus_res_n
);

    int unsigned wr_low_n;
    int unsigned rd_low_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_low_n <= 0;
            rd_low_n <= 0;
        end else begin
            wr_low_n <= bus_wr_n ? 0 : wr_low_n + 1;
            rd_low_n <= bus_rd_n ? 0 : rd_low_n + 1;
        end
    end

    // R1
    idle_levels_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (bus_cs_n && bus_wr_n && bus_rd_n && bus_res_n && bus_dc && !drive_en && !done));

    // R3
    dc_cmd_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_dc |-> (!bus_cs_n && drive_en));

    // R4
    wr_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_wr_n) |-> (wr_low_n == WR_CYC));

    // R4
    wr_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_wr_n) |-> $past(drive_en));

    // R5
    rd_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_rd_n) |-> (rd_low_n == RD_CYC));

    // R7
    no_drive_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_n |-> !drive_en);

    // R7
    release_before_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_rd_n) |-> !$past(drive_en));

    // R9
    strobe_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr_n || !bus_rd_n) |-> !bus_cs_n);

    // R10
    pulse_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_res_n |-> (busy && bus_cs_n && bus_wr_n));

    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

bind lcd_pbus_master lcd_pbus_checker #(.WR_CYC(WR_CYC), .RD_CYC(RD_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .drive_en  (drive_en),
    .bus_cs_n  (bus_cs_n),
    .bus_dc    (bus_dc),
    .bus_wr_n  (bus_wr_n),
    .bus_rd_n  (bus_rd_n),
    .bus_res_n (bus_res_n)
);

// File: tb/lcd_pbus_master_tb.sv
`timescale 1ns/1ps
module lcd_pbus_master_tb;

    localparam int CLK_NS = 20;
    localparam int WR_E   = (50 + CLK_NS - 1) / CLK_NS;
    localparam int RDS_E  = (250 + CLK_NS - 1) / CLK_NS;
    localparam int RDL_E  = (150 + CLK_NS - 1) / CLK_NS;
    localparam int RD_E   = (RDS_E > RDL_E) ? RDS_E : RDL_E;
    localparam int GAP_E  = (60 + CLK_NS - 1) / CLK_NS;
    localparam int RST_E  = 10;
    localparam int NV     = 7;

    // {kind, word to write, word the panel returns}
    localparam logic [33:0] VEC [NV] = '{
        {2'b00, 16'h002C, 16'h0000},
        {2'b01, 16'hA55A, 16'h0000},
        {2'b10, 16'h0000, 16'h9341},
        {2'b01, 16'h00FF, 16'h0000},
        {2'b00, 16'hB7C3, 16'h0000},
        {2'b10, 16'h0000, 16'h8001},
        {2'b01, 16'hFF00, 16'h0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'b00;
    logic [15:0] req_word = '0;
    logic        busy, done;
    logic [15:0] rd_word;
    logic        bus_cs_n, bus_dc, bus_wr_n, bus_rd_n, bus_res_n;
    wire  [7:0]  bus_d;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    lcd_pbus_master u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_word(req_word), .busy(busy), .done(done), .rd_word(rd_word),
        .bus_cs_n(bus_cs_n), .bus_dc(bus_dc), .bus_wr_n(bus_wr_n),
        .bus_rd_n(bus_rd_n), .bus_res_n(bus_res_n), .bus_d(bus_d)
    );

    // Panel model and monitor
    logic        mon_clr = 1'b0;
    logic [15:0] panel_word = '0;
    int          ncap, wr_low, wr_bad, setup_bad, rd_seen, rd_bad, rd_byte_no;
    int          gap_cnt, gap_last, cs_rise, rst_low, rst_bad;
    logic [7:0]  cap_b [4];
    logic        cap_dc [4];
    logic        prev_wr = 1'b1, prev_rd = 1'b1, prev_cs = 1'b1;
    logic [7:0]  prev_d = '0;
    logic [7:0]  good_byte, panel_byte;
    logic        panel_en;

    assign good_byte  = (rd_byte_no == 0) ? panel_word[15:8] : panel_word[7:0];
    assign panel_byte = (rd_seen == RD_E) ? good_byte : ~good_byte;
    assign panel_en   = !bus_rd_n && !bus_cs_n;
    assign bus_d      = panel_en ? panel_byte : 8'bz;

    always @(negedge clk) begin
        if (mon_clr) begin
            ncap <= 0; wr_low <= 0; wr_bad <= 0; setup_bad <= 0;
            rd_seen <= 0; rd_bad <= 0; rd_byte_no <= 0;
            gap_cnt <= 0; gap_last <= 0; cs_rise <= 0; rst_low <= 0; rst_bad <= 0;
        end else begin
            if (!bus_wr_n) begin
                wr_low <= wr_low + 1;
                if (bus_d != prev_d) setup_bad <= setup_bad + 1;
            end else if (!prev_wr) begin
                if (wr_low != WR_E) wr_bad <= wr_bad + 1;
                if (ncap < 4) begin
                    cap_b[ncap]  <= bus_d;
                    cap_dc[ncap] <= bus_dc;
                end
                ncap   <= ncap + 1;
                wr_low <= 0;
            end
            if (!bus_rd_n) begin
                rd_seen <= rd_seen + 1;
                if (prev_rd && rd_byte_no == 1) gap_last <= gap_cnt;
            end else begin
                if (!prev_rd) begin
                    if (rd_seen != RD_E) rd_bad <= rd_bad + 1;
                    rd_byte_no <= rd_byte_no + 1;
                    gap_cnt    <= 1;
                end else if (!bus_cs_n) begin
                    gap_cnt <= gap_cnt + 1;
                end
                rd_seen <= 0;
            end
            if (bus_cs_n && !prev_cs) cs_rise <= cs_rise + 1;
            if (!bus_res_n) begin
                rst_low <= rst_low + 1;
                if (!busy || !bus_cs_n || !bus_wr_n) rst_bad <= rst_bad + 1;
            end
        end
        prev_wr <= bus_wr_n;
        prev_rd <= bus_rd_n;
        prev_cs <= bus_cs_n;
        prev_d  <= bus_d;
    end

    task automatic check_eq(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic launch(logic [1:0] k, logic [15:0] w, logic [15:0] pw);
        @(posedge clk); #2;
        mon_clr = 1'b1; panel_word = pw;
        req_valid = 1'b1; req_kind = k; req_word = w;
        @(posedge clk); #2;
        mon_clr = 1'b0; req_valid = 1'b0;
        check_eq("R11 busy after accept", int'(busy), 1);
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 2000) begin
            @(posedge clk); #2;
            n++;
        end
        check_eq("R11 done reached", int'(done), 1);
        @(negedge clk); #2;
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        #2 rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #2;
        // R1 reset state
        check_eq("R1 idle levels", {28'd0, bus_cs_n, bus_wr_n, bus_rd_n, bus_res_n}, 4'hF);
        check_eq("R1 dc high", int'(bus_dc), 1);
        check_eq("R1 busy/done low", {30'd0, busy, done}, 0);

        for (int i = 0; i < NV; i++) begin
            logic [1:0]  k;
            logic [15:0] w, pw;
            k  = VEC[i][33:32];
            w  = VEC[i][31:16];
            pw = VEC[i][15:0];
            launch(k, w, pw);
            wait_done();
            if (k == 2'b10) begin
                check_eq("R6 R7 read word", int'(rd_word), int'(pw));
                check_eq("R5 read low width", rd_bad, 0);
                check_eq("R8 read gap", gap_last, GAP_E);
            end else begin
                check_eq("R2 byte count", ncap, 2);
                check_eq("R2 high byte", int'(cap_b[0]), int'(w[15:8]));
                check_eq("R2 low byte", int'(cap_b[1]), int'(w[7:0]));
                check_eq("R3 dc on bytes", {30'd0, cap_dc[0], cap_dc[1]}, (k == 2'b00) ? 0 : 3);
                check_eq("R4 write low width", wr_bad, 0);
                check_eq("R4 byte set up before strobe", setup_bad, 0);
            end
            check_eq("R9 single cs window", cs_rise, 1);
            check_eq("R3 dc back high", int'(bus_dc), 1);
        end

        // R11 done lasts one cycle, then idle
        @(posedge clk); #2;
        check_eq("R11 done single", {30'd0, busy, done}, 0);

        // R11 request while busy is ignored
        launch(2'b01, 16'h1234, 16'h0000);
        @(posedge clk); #2;
        req_valid = 1'b1; req_kind = 2'b00; req_word = 16'hFFFF;
        @(posedge clk); #2;
        req_valid = 1'b0;
        wait_done();
        check_eq("R11 ignored: byte count", ncap, 2);
        check_eq("R11 ignored: bytes", {cap_b[0], cap_b[1]}, 16'h1234);
        check_eq("R11 ignored: dc", {30'd0, cap_dc[0], cap_dc[1]}, 3);
        repeat (5) @(posedge clk);
        #2;
        check_eq("R11 no extra transfer", int'(busy), 0);

        // R10 reset pulse
        launch(2'b11, 16'h0000, 16'h0000);
        wait_done();
        check_eq("R10 pulse width", rst_low, RST_E);
        check_eq("R10 busy and cs during pulse", rst_bad, 0);
        check_eq("R10 no write", ncap, 0);
        check_eq("R10 reset line released", int'(bus_res_n), 1);

        @(posedge clk); #2;
        check_eq("R1 idle after run", {28'd0, bus_cs_n, bus_wr_n, bus_rd_n, bus_res_n}, 4'hF);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule